// File: doc/BRIEF.md
# Burst Address Counter with Address Readback

This block generates the word address for one port of a synchronous dual-port memory. It holds a 15-bit word address, which covers 32K words of 36 bits. On a rising clock edge the address can be loaded from an external bus, advanced by one for burst access, cleared to zero, or held. All three controls are active-low and are sampled on that edge.

A readback select puts the port into a hold-and-read mode. In this mode the counter keeps its value and the current address appears, zero-extended, on the 36-bit data word in place of memory contents. This lets software or a host see the address the burst has reached. The memory array, the data path to the array and any bus-width matching sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: When clr_n is low at a rising edge, addr becomes 0 after that edge. This overrides every other control, including readback.
- R2: When strb_n and cnt_en_n are both low, clr_n is high and rdbk is low at a rising edge, addr takes the value of ext_addr after that edge.
- R3: When strb_n is low but cnt_en_n is high (with clr_n high), ext_addr is ignored and addr keeps its value.
- R4: When cnt_en_n is low, strb_n is high, clr_n is high and rdbk is low at a rising edge, addr advances by one after that edge.
- R5: Advancing from the top address 0x7FFF gives 0x0000.
- R6: When clr_n, strb_n and cnt_en_n are all high, addr keeps its value.
- R7: While rdbk is high and clr_n is high, addr keeps its value whatever strb_n, cnt_en_n and ext_addr are.
- R8: While rdbk is high, rd_data[14:0] equals addr and rd_data[35:15] is zero, in the same cycle. While rdbk is low, rd_data is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| strb_n | input | 1 | Address strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| clr_n | input | 1 | Counter clear, active low, synchronous |
| rdbk | input | 1 | Hold-and-read select, active high |
| ext_addr | input | 15 | External address to load |
| addr | output | 15 | Current counter address |
| rd_data | output | 36 | Zero-extended address during readback, else zero |

## Verification
Two pairs of functions can land in the same cycle. The first pair is clear with load, and the second is load with readback. The bench provokes each pair by asserting clear together with a strobe-and-enable that carries a non-zero address. It also raises readback while strobe and enable ask for a load or an increment. A clear must give zero in the first case, and the held address in the second. The reference model in the bench decides which control wins, and that prediction is compared against addr and rd_data one edge later.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              strb_n,
  input  logic              cnt_en_n,
  input  logic              clr_n,
  input  logic              rdbk,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic              do_load;
  logic              do_step;
  logic [ADDR_W-1:0] cnt_q;

  assign do_load = !rdbk && !strb_n && !cnt_en_n;
  assign do_step = !rdbk &&  strb_n && !cnt_en_n;

  always_ff @(posedge clk) begin
    if (!clr_n)       cnt_q <= '0;
    else if (do_load) cnt_q <= ext_addr;
    else if (do_step) cnt_q <= cnt_q + 1'b1;
  end

  assign addr    = cnt_q;
  assign rd_data = rdbk ? {{PAD_W{1'b0}}, cnt_q} : '0;
endmodule

module burst_addr_gen_chk #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              strb_n,
  input logic              cnt_en_n,
  input logic              clr_n,
  input logic              rdbk,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rd_data
);
  logic primed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) primed <= 1'b1;

  a_r1_clear: assert property (@(posedge clk) !clr_n |=> addr == '0);

  a_r2_load: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !rdbk && !strb_n && !cnt_en_n) |=> addr == $past(ext_addr));

  a_r4_step: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && !rdbk && strb_n && !cnt_en_n) |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R3, R6, R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!primed)
    (clr_n && (rdbk || cnt_en_n)) |=> $stable(addr));

  a_r8_readback: assert property (@(posedge clk) disable iff (!primed)
    rdbk |-> (rd_data[ADDR_W-1:0] == addr) && (rd_data[DATA_W-1:ADDR_W] == '0));

  a_r8_idle: assert property (@(posedge clk) disable iff (!primed)
    !rdbk |-> rd_data == '0);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;
  localparam int AW = 15;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          strb_n = 1'b1, cnt_en_n = 1'b1, clr_n = 1'b1, rdbk = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd_data;

  typedef struct {
    logic [AW-1:0] a;
    logic          rb;
    string         tag;
  } item_t;

  item_t         q[$];
  int            checks = 0, errors = 0;
  logic [AW-1:0] model = '0;
  bit            done = 1'b0;

  burst_addr_gen i_burst_addr_gen (.*);

  always #2.5 clk = ~clk;

  task automatic step(input logic s, input logic e, input logic c, input logic r,
                      input logic [AW-1:0] x, input string tag);
    item_t it;
    @(negedge clk);
    strb_n = s; cnt_en_n = e; clr_n = c; rdbk = r; ext_addr = x;
    if (!c)           model = '0;
    else if (r)       model = model;
    else if (!s && !e) model = x;
    else if (!e)      model = model + 1'b1;
    it.a = model; it.rb = r; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [DW-1:0] exp_rd;
      it = q.pop_front();
      exp_rd = it.rb ? {{(DW-AW){1'b0}}, it.a} : '0;
      checks++;
      if (addr !== it.a) begin
        errors++;
        $display("FAIL %s addr actual=%h expected=%h", it.tag, addr, it.a);
      end
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL R8 rd_data actual=%h expected=%h", rd_data, exp_rd);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1, 1, 0, 0, 15'h5555, "R1 reset clear");
    step(0, 0, 1, 0, 15'h1234, "R2 load");
    step(1, 0, 1, 0, 15'h7777, "R4 increment");
    step(1, 0, 1, 0, 15'h0000, "R4 increment");
    step(0, 1, 1, 0, 15'h4321, "R3 strobe without enable");
    step(1, 1, 1, 0, 15'h2222, "R6 idle hold");
    step(1, 1, 1, 1, 15'h2222, "R7 readback idle");
    step(0, 0, 1, 1, 15'h0ABC, "R7 readback blocks load");
    step(1, 0, 1, 1, 15'h0000, "R7 readback blocks increment");
    step(0, 0, 1, 0, 15'h7FFE, "R2 load near top");
    step(1, 0, 1, 0, 15'h0000, "R4 to top");
    step(1, 0, 1, 0, 15'h0000, "R5 wrap");
    step(1, 0, 1, 1, 15'h0000, "R8 readback at zero");
    step(0, 0, 1, 0, 15'h6A5B, "R2 load");
    step(0, 0, 0, 0, 15'h3C3C, "R1 clear beats load");
    step(0, 0, 1, 0, 15'h7FFF, "R2 load top");
    step(1, 1, 1, 1, 15'h0000, "R8 readback top");
    step(0, 0, 0, 1, 15'h1111, "R1 clear beats readback");
    for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 15'h0000, "R4 burst");
    step(1, 1, 1, 1, 15'h0000, "R8 readback after burst");
    step(1, 1, 1, 0, 15'h0000, "R6 final hold");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule